// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block owns the status and control byte of a small serial non-volatile memory and rules on every write before it reaches storage. Commands arrive already decoded: set or clear the write-enable latch, rewrite the status byte with a data byte, or write the array at a 15-bit address. An active-low protect pin, together with an enable bit held in the status byte, can freeze the status byte. Two block-protect bits fence off the top quarter, the top half or all of the address space. A separate identification page has its own select latch and a one-way lock.

Each write request receives a single-cycle grant or reject pulse one clock after it arrives. A granted write holds the busy flag for a fixed number of cycles, which models the self-timed programming cycle. The status byte is always visible for reads. Bits that stand for non-volatile storage are plain registers, and their reset values are set by parameters.

Top module: `wp_status_ctrl`

## Requirements
- R1: The status byte reads {enable-hw-protect[7], id-page-select[6], 0[5], id-page-lock[4], block-protect[3:2], write-enable[1], busy[0]}. After reset, bits 6, 1 and 0 are 0, and bits 7, 4 and 3:2 take their parameterised reset values.
- R2: A granted write raises busy on the next clock edge. Busy stays 1 for exactly BUSY_CYCLES cycles. Any write request sampled while busy is 1 is rejected, and written values never change bit 0.
- R3: A write-enable command sets bit 1 and a write-disable command clears it. Both commands are ignored while busy. Bit 1 also clears when a granted write finishes its busy period. Any write request with bit 1 at 0 is rejected.
- R4: Block-protect 00 locks no address, 01 locks 0x6000–0x7FFF, 10 locks 0x4000–0x7FFF and 11 locks 0x0000–0x7FFF. A main-array write to a locked address is rejected.
- R5: While the protect pin is low and bit 7 is 1, status writes are rejected. Array writes to unlocked addresses are still granted while bit 1 is 1.
- R6: While the protect pin is high or bit 7 is 0, a status write is granted whenever bit 1 is 1 and the block is not busy. Bits 7 and 3:2 change only through a granted status write.
- R7: With bit 6 at 1, array writes target the identification page and ignore the block-protect fence. Bit 6 clears when a granted array write finishes, and also on a read-done pulse.
- R8: With bit 4 at 1, every identification-page write is rejected. No later status write can clear bit 4.
- R9: A status write whose data has both bit 6 and bit 4 at 1 changes neither bit 6 nor bit 4. Its other fields still apply.
- R10: Bit 5 always reads 0. Data bits 5, 1 and 0 of a status write have no effect.
- R11: Only one request is taken per cycle, with this priority: status write, then array write, then write-enable, then write-disable. Lower-priority requests in the same cycle are ignored. Each taken write request gets exactly one of grant or reject in the next cycle. Other cycles get neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Active-low hardware protect pin |
| cmd_wren | input | 1 | Set write-enable latch |
| cmd_wrdi | input | 1 | Clear write-enable latch |
| sr_wr_req | input | 1 | Status byte write request |
| sr_wr_data | input | 8 | Status byte write data |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Array write address |
| rd_done | input | 1 | Pulse marking a completed read |
| status_byte | output | 8 | Current status byte |
| wr_grant | output | 1 | Write granted (one cycle) |
| wr_reject | output | 1 | Write rejected (one cycle) |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
Assertions check several rules on every cycle: one answer per write request, rejection while busy, while the write-enable latch is low or under hardware protection, full-array lockout, stickiness of the page lock, and the rule against setting both page bits at once. The exact busy length, the quarter and half address boundaries, self-clearing of the page select after a write or a read, and command priority show up only in the bench's directed scenarios. There, a behavioural reference model is compared against every output on every cycle.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;
   localparam int SB_WPEN = 7;
   localparam int SB_IPL  = 6;
   localparam int SB_ZERO = 5;
   localparam int SB_LIP  = 4;
   localparam int SB_BPH  = 3;
   localparam int SB_BPL  = 2;
   localparam int SB_WEL  = 1;
   localparam int SB_BUSY = 0;

   typedef enum logic [1:0] {
      BP_NONE    = 2'b00,
      BP_QUARTER = 2'b01,
      BP_HALF    = 2'b10,
      BP_FULL    = 2'b11
   } bp_mode_e;
endpackage

// File: rtl/wpsc_range_lock.sv
module wpsc_range_lock #(
   parameter int ADDR_W = 15
) (
   input  logic [1:0]        bp_mode,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   import wpsc_pkg::*;
   localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W-1);
   localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W-2);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wpsc_range_lock: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      unique case (bp_mode_e'(bp_mode))
         BP_NONE:    locked = 1'b0;
         BP_QUARTER: locked = (addr >= QUARTER_BASE);
         BP_HALF:    locked = (addr >= HALF_BASE);
         default:    locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpsc_busy_timer.sv
module wpsc_busy_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic finish
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("wpsc_busy_timer: CYCLES must be at least 1");
      end
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
            else            busy_q <= 1'b0;
         end
         assign busy   = busy_q;
         assign finish = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (start)          cnt_q <= CNT_W'(CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign busy   = (cnt_q != '0);
         assign finish = (cnt_q == CNT_W'(1));
      end
   endgenerate

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> busy);
   assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !start) |=> !busy);
endmodule

// File: rtl/wpsc_status_reg.sv
module wpsc_status_reg #(
   parameter logic       RST_WPEN = 1'b0,
   parameter logic [1:0] RST_BP   = 2'b00,
   parameter logic       RST_LIP  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sr_load,
   input  logic       wpen_d,
   input  logic       ipl_d,
   input  logic       lip_d,
   input  logic [1:0] bp_d,
   input  logic       set_wel,
   input  logic       clr_wel,
   input  logic       clr_ipl,
   output logic       wpen,
   output logic       ipl,
   output logic       lip,
   output logic [1:0] bp,
   output logic       wel
);
   logic both_set;
   assign both_set = ipl_d & lip_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpen <= RST_WPEN;
         bp   <= RST_BP;
      end else if (sr_load) begin
         wpen <= wpen_d;
         bp   <= bp_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lip <= RST_LIP;
      else if (sr_load && !both_set) lip <= lip | lip_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ipl <= 1'b0;
      else if (sr_load && !both_set) ipl <= ipl_d;
      else if (clr_ipl)              ipl <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wel <= 1'b0;
      else if (clr_wel) wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
   end

   assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lip |=> lip);
   assert_both_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_load && both_set && !clr_ipl) |=> ($stable(ipl) && $stable(lip)));
   assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_load |=> ($stable(wpen) && $stable(bp)));
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
   parameter int         ADDR_W      = 15,
   parameter int         BUSY_CYCLES = 8,
   parameter logic       RST_WPEN    = 1'b0,
   parameter logic [1:0] RST_BP      = 2'b00,
   parameter logic       RST_LIP     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              sr_wr_req,
   input  logic [7:0]        sr_wr_data,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_wr_addr,
   input  logic              rd_done,
   output logic [7:0]        status_byte,
   output logic              wr_grant,
   output logic              wr_reject,
   output logic              busy
);
   import wpsc_pkg::*;

   logic       wpen, ipl, lip, wel, finish, locked, hw_lock;
   logic [1:0] bp;
   logic       sel_sr, sel_arr, sel_en, sel_dis;
   logic       grant_sr, grant_arr, op_arr_q;
   logic [2:0] sr_data_unused;

   assign sr_data_unused = {sr_wr_data[SB_ZERO], sr_wr_data[SB_WEL], sr_wr_data[SB_BUSY]};

   // one request per cycle, fixed priority
   assign sel_sr  = sr_wr_req;
   assign sel_arr = arr_wr_req & ~sr_wr_req;
   assign sel_en  = cmd_wren & ~sr_wr_req & ~arr_wr_req;
   assign sel_dis = cmd_wrdi & ~cmd_wren & ~sr_wr_req & ~arr_wr_req;

   assign hw_lock   = ~wp_n & wpen;
   assign grant_sr  = sel_sr & ~busy & wel & ~hw_lock;
   assign grant_arr = sel_arr & ~busy & wel & (ipl ? ~lip : ~locked);

   wpsc_range_lock #(.ADDR_W(ADDR_W)) range_i (
      .bp_mode (bp),
      .addr    (arr_wr_addr),
      .locked  (locked)
   );

   wpsc_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (grant_sr | grant_arr),
      .busy   (busy),
      .finish (finish)
   );

   wpsc_status_reg #(.RST_WPEN(RST_WPEN), .RST_BP(RST_BP), .RST_LIP(RST_LIP)) sreg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sr_load (grant_sr),
      .wpen_d  (sr_wr_data[SB_WPEN]),
      .ipl_d   (sr_wr_data[SB_IPL]),
      .lip_d   (sr_wr_data[SB_LIP]),
      .bp_d    (sr_wr_data[SB_BPH:SB_BPL]),
      .set_wel (sel_en & ~busy),
      .clr_wel (finish | (sel_dis & ~busy)),
      .clr_ipl ((finish & op_arr_q) | rd_done),
      .wpen    (wpen),
      .ipl     (ipl),
      .lip     (lip),
      .bp      (bp),
      .wel     (wel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_grant  <= 1'b0;
         wr_reject <= 1'b0;
         op_arr_q  <= 1'b0;
      end else begin
         wr_grant  <= grant_sr | grant_arr;
         wr_reject <= (sel_sr | sel_arr) & ~(grant_sr | grant_arr);
         if (grant_sr | grant_arr) op_arr_q <= grant_arr;
      end
   end

   always_comb begin
      status_byte          = '0;
      status_byte[SB_WPEN] = wpen;
      status_byte[SB_IPL]  = ipl;
      status_byte[SB_LIP]  = lip;
      status_byte[SB_BPH:SB_BPL] = bp;
      status_byte[SB_WEL]  = wel;
      status_byte[SB_BUSY] = busy;
   end

   assert_wel_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((sr_wr_req || arr_wr_req) && !status_byte[SB_WEL]) |=> wr_reject);
   assert_busy_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((sr_wr_req || arr_wr_req) && busy) |=> wr_reject);
   assert_hw_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req && !wp_n && status_byte[SB_WPEN]) |=> wr_reject);
   assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_req && !sr_wr_req && status_byte[SB_BPH:SB_BPL] == 2'b11
       && !status_byte[SB_IPL]) |=> wr_reject);
   assert_one_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req || arr_wr_req) |=> (wr_grant != wr_reject));
   assert_no_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(sr_wr_req || arr_wr_req) |=> (!wr_grant && !wr_reject));
endmodule

// File: tb/wp_status_ctrl_tb_top.sv
module wp_status_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BUSY_N     = 5;
   localparam int AW         = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_n = 1'b1, cmd_wren = 1'b0, cmd_wrdi = 1'b0;
   logic          sr_wr_req = 1'b0, arr_wr_req = 1'b0, rd_done = 1'b0;
   logic [7:0]    sr_wr_data = '0;
   logic [AW-1:0] arr_wr_addr = '0;
   logic [7:0]    status_byte;
   logic          wr_grant, wr_reject, busy;

   int n_checks = 0;
   int n_fail   = 0;
   bit running  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_status_ctrl #(.ADDR_W(AW), .BUSY_CYCLES(BUSY_N)) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .arr_wr_req(arr_wr_req),
      .arr_wr_addr(arr_wr_addr), .rd_done(rd_done), .status_byte(status_byte),
      .wr_grant(wr_grant), .wr_reject(wr_reject), .busy(busy)
   );

   // behavioural reference model
   int m_wpen = 0, m_ipl = 0, m_lip = 0, m_bp = 0, m_wel = 0, m_cnt = 0, m_arr = 0;
   int m_grant = 0, m_rej = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wpen = 0; m_ipl = 0; m_lip = 0; m_bp = 0; m_wel = 0;
         m_cnt = 0; m_arr = 0; m_grant = 0; m_rej = 0;
      end else begin
         int was_busy, fin, hp, s_sr, s_arr, s_en, s_dis, lk, g_sr, g_arr, both, clr;
         int a;
         a        = int'(arr_wr_addr);
         was_busy = (m_cnt != 0);
         fin      = (m_cnt == 1);
         hp       = (!wp_n && m_wpen != 0);
         s_sr     = sr_wr_req;
         s_arr    = arr_wr_req && !sr_wr_req;
         s_en     = cmd_wren && !sr_wr_req && !arr_wr_req;
         s_dis    = cmd_wrdi && !cmd_wren && !sr_wr_req && !arr_wr_req;
         lk       = (m_bp == 3) || (m_bp == 2 && a >= 16384) || (m_bp == 1 && a >= 24576);
         g_sr     = s_sr && !was_busy && m_wel != 0 && !hp;
         g_arr    = s_arr && !was_busy && m_wel != 0 && (m_ipl != 0 ? m_lip == 0 : !lk);
         both     = sr_wr_data[6] && sr_wr_data[4];
         clr      = (fin && m_arr != 0) || rd_done;
         if (g_sr || g_arr) begin m_cnt = BUSY_N; m_arr = g_arr; end
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         if (fin) m_wel = 0;
         else if (!was_busy && s_en) m_wel = 1;
         else if (!was_busy && s_dis) m_wel = 0;
         if (g_sr && !both) m_ipl = sr_wr_data[6];
         else if (clr) m_ipl = 0;
         if (g_sr && !both && sr_wr_data[4]) m_lip = 1;
         if (g_sr) begin m_wpen = sr_wr_data[7]; m_bp = int'(sr_wr_data[3:2]); end
         m_grant = g_sr || g_arr;
         m_rej   = (s_sr || s_arr) && !(g_sr || g_arr);
      end
   end

   function automatic logic [7:0] model_status();
      return {m_wpen[0], m_ipl[0], 1'b0, m_lip[0], m_bp[1:0], m_wel[0], (m_cnt != 0)};
   endfunction

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (running) begin
         n_checks++;
         if (status_byte !== model_status() || wr_grant !== m_grant[0] ||
             wr_reject !== m_rej[0] || busy !== (m_cnt != 0)) begin
            n_fail++;
            $display("FAIL R1/R2/R11 per-cycle: status=%h grant=%b rej=%b busy=%b expected status=%h grant=%0d rej=%0d busy=%0d",
                     status_byte, wr_grant, wr_reject, busy, model_status(), m_grant, m_rej, m_cnt != 0);
         end
      end
   end

   task automatic expect8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cmd_wren = 0; cmd_wrdi = 0; sr_wr_req = 0; arr_wr_req = 0; rd_done = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic wren();
      cmd_wren = 1; tick();
   endtask

   task automatic sr_write(input logic [7:0] d);
      sr_wr_req = 1; sr_wr_data = d; tick();
   endtask

   task automatic arr_write(input int a);
      arr_wr_req = 1; arr_wr_addr = AW'(a); tick();
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      int guard;
      for (guard = 0; guard < 20000; guard++) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int nb;
      repeat (3) @(negedge clk);
      expect8(status_byte, 8'h00, "R1 reset status");
      rst_n = 1;
      @(negedge clk);
      running = 1;

      // R3: no enable latch, write rejected
      arr_write(16'h0010);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R3 write with latch low");
      wren();
      expect8(status_byte, 8'h02, "R3 enable latch set");
      cmd_wrdi = 1; tick();
      expect8(status_byte, 8'h00, "R3 enable latch cleared");

      // R9 + R10: both page bits set, junk in bits 5/1/0
      wren();
      sr_write(8'hFF);
      expect8(status_byte, 8'h8F, "R9 both-set ignored, R10 bit5 zero");
      expect8({7'b0, wr_grant}, 8'h01, "R6 status write granted");
      nb = 0;
      while (busy) begin nb++; @(negedge clk); end
      expect8(8'(nb), 8'(BUSY_N), "R2 busy length");
      expect8(status_byte, 8'h8C, "R3 latch cleared after finish");

      // R4 full lock
      wren();
      arr_write(0);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R4 full lock at 0x0000");

      // half lock, then R5 hardware protection
      sr_write(8'h88); wait_idle();
      wp_n = 0;
      wren();
      arr_write(16'h3FFF);
      expect8({6'b0, wr_grant, wr_reject}, 8'h02, "R5 unlocked write under hw protect");
      arr_write(16'h0001);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R2 reject while busy");
      cmd_wren = 1; tick();
      wait_idle();
      expect8(status_byte, 8'h88, "R3 wren ignored while busy");
      wren();
      arr_write(16'h4000);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R4 half lock at 0x4000");
      sr_write(8'h00);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R5 status write under hw protect");
      wp_n = 1;
      sr_write(8'h04);
      expect8({6'b0, wr_grant, wr_reject}, 8'h02, "R6 status write with pin high");
      wait_idle();
      expect8(status_byte, 8'h04, "R6 quarter mode, hw enable off");
      wren(); arr_write(16'h5FFF);
      expect8({6'b0, wr_grant, wr_reject}, 8'h02, "R4 quarter allows 0x5FFF");
      wait_idle();
      wren(); arr_write(16'h6000);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R4 quarter locks 0x6000");

      // R7 identification page select
      sr_write(8'h44); wait_idle();
      expect8(status_byte, 8'h44, "R7 page select set");
      wren(); arr_write(16'h7FFF);
      expect8({6'b0, wr_grant, wr_reject}, 8'h02, "R7 page write bypasses fence");
      wait_idle();
      expect8(status_byte, 8'h04, "R7 page select cleared after write");
      wren(); sr_write(8'h44); wait_idle();
      rd_done = 1; tick();
      expect8(status_byte, 8'h04, "R7 page select cleared by read");

      // R8 page lock
      wren(); sr_write(8'h14); wait_idle();
      wren(); sr_write(8'h44); wait_idle();
      expect8(status_byte, 8'h54, "R8 lock and select");
      wren(); arr_write(16'h0002);
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R8 locked page write rejected");
      sr_write(8'h00); wait_idle();
      expect8(status_byte, 8'h10, "R8 lock survives clearing write");

      // R11 priority: status write beats wren in same cycle
      sr_wr_req = 1; sr_wr_data = 8'h00; cmd_wren = 1; tick();
      expect8({6'b0, wr_grant, wr_reject}, 8'h01, "R11 status write taken over wren");
      expect8(status_byte, 8'h10, "R11 lower-priority wren ignored");
      repeat (3) @(negedge clk);

      running = 0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule